// File: doc/BRIEF.md
# Quadrature-Phase Instruction Sequencer

This block sets the instruction-cycle rhythm of a small 8-bit core with separate program and data memories. It counts the oscillator clock in groups of four and raises exactly one of four phase strobes on each clock. The four strobes, in order, are decode (or a forced no-operation), operand read, data processing and result write. Four oscillator clocks make one instruction cycle.

The block also holds the two-stage pipeline. While one instruction executes, the next 14-bit word is fetched. The fetch strobe is high during the fourth phase, and the program memory word present in that phase is captured into the instruction register on the edge that closes the cycle. From the next first phase onward, that word is the executing instruction. Every instruction is a single word, so one fetch per cycle covers all of them.

The execute logic can raise a flush request on any clock of a cycle, for example on a jump or on a write to the program counter. The prefetched word is then thrown away, and the following cycle executes the no-operation word (all zeros) in its place.

Top module: `qps_sequencer`

## Requirements
- R1: While reset is high, and directly after it, the phase strobes read 4'b0001 (bit 0 = first phase), the instruction register holds the no-operation word 14'h0000, and the fetch strobe is low.
- R2: Exactly one bit of the 4-bit phase strobe vector is high on every clock out of reset.
- R3: The strobes advance one position per clock in the order bit 0, bit 1, bit 2, bit 3, and then back to bit 0.
- R4: The fetch strobe is high exactly while phase bit 3 is high, so it is high once every four clocks.
- R5: If no flush was requested during a cycle, the instruction register shows, from the next phase-bit-0 clock onward, the program word that was present during that cycle's phase bit 3.
- R6: The instruction register changes only on the edge from phase bit 3 to phase bit 0. It stays constant for the other three clocks of a cycle.
- R7: A flush request on any one of the four clocks of a cycle makes the instruction register hold 14'h0000 for the whole of the next cycle.
- R8: A flush lasts one cycle only. The cycle after the forced no-operation loads its fetched word normally.
- R9: The program word in phase bits 0, 1 and 2 has no effect on the instruction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| pm_rdata | input | 14 | Program memory read word |
| flush_req | input | 1 | Request from execute to discard the prefetched word |
| phase_stb | output | 4 | One-hot phase strobes, bit 0 = decode phase |
| fetch_stb | output | 1 | Program memory fetch strobe |
| instr | output | 14 | Current instruction register |

## Verification
The bench feeds distinct words on consecutive cycles and a different filler word in the three non-fetch phases. A captured filler word shows a capture in the wrong phase, and a repeated word shows a missed load. It places flushes on each of the four phases in turn, on two back-to-back cycles, and on a cycle that fetches all ones. These cases tell a flush that is sampled only in some phases apart from one that is held sticky, and a one-cycle kill apart from one that lingers. A fetched word equal to the no-operation value, and an all-ones word, exercise both extremes of the register path.

// File: rtl/qps_pkg.sv
package qps_pkg;
    localparam int IW   = 14;
    localparam int NPH  = 4;
    localparam int PHW  = $clog2(NPH);

    typedef logic [IW-1:0] iword_t;
    localparam iword_t NOP_WORD = '0;

    typedef enum logic [PHW-1:0] {
        PH_DECODE  = 2'd0,
        PH_READ    = 2'd1,
        PH_PROCESS = 2'd2,
        PH_WRITE   = 2'd3
    } phase_e;

    typedef struct packed {
        iword_t word;
        logic   killed;
    } slot_t;

    function automatic phase_e next_phase(phase_e p);
        return (p == PH_WRITE) ? PH_DECODE : phase_e'(p + 1'b1);
    endfunction
endpackage

// File: rtl/qps_phase_gen.sv
module qps_phase_gen
    import qps_pkg::*;
#(
    parameter int N = NPH
) (
    input  logic         clk,
    input  logic         rst,
    output phase_e       phase,
    output logic [N-1:0] stb,
    output logic         cyc_end
);
    phase_e cur;

    always_ff @(posedge clk) begin
        if (rst) cur <= PH_DECODE;
        else     cur <= next_phase(cur);
    end

    for (genvar g = 0; g < N; g++) begin : g_stb
        assign stb[g] = (cur == phase_e'(g));
    end

    assign phase   = cur;
    assign cyc_end = (cur == PH_WRITE);
endmodule

// File: rtl/qps_flush_track.sv
module qps_flush_track (
    input  logic clk,
    input  logic rst,
    input  logic flush_req,
    input  logic cyc_end,
    output logic kill
);
    logic pend;

    always_ff @(posedge clk) begin
        if (rst)          pend <= 1'b0;
        else if (cyc_end) pend <= 1'b0;
        else if (flush_req) pend <= 1'b1;
    end

    assign kill = pend | flush_req;
endmodule

// File: rtl/qps_ir_stage.sv
module qps_ir_stage
    import qps_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cyc_end,
    input  logic   kill,
    input  iword_t rdata,
    output iword_t ir
);
    slot_t nxt;
    slot_t held;

    always_comb begin
        nxt.killed = kill;
        nxt.word   = kill ? NOP_WORD : rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held.word   <= NOP_WORD;
            held.killed <= 1'b1;
        end else if (cyc_end) begin
            held <= nxt;
        end
    end

    assign ir = held.word;
endmodule

// File: rtl/qps_sequencer.sv
module qps_sequencer
    import qps_pkg::*;
#(
    parameter int W = IW,
    parameter int P = NPH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pm_rdata,
    input  logic         flush_req,
    output logic [P-1:0] phase_stb,
    output logic         fetch_stb,
    output logic [W-1:0] instr
);
    phase_e ph;
    logic   cyc_end;
    logic   kill;
    iword_t ir_q;

    qps_phase_gen #(.N(P)) u_phase (
        .clk(clk), .rst(rst), .phase(ph), .stb(phase_stb), .cyc_end(cyc_end)
    );

    qps_flush_track u_flush (
        .clk(clk), .rst(rst), .flush_req(flush_req), .cyc_end(cyc_end), .kill(kill)
    );

    qps_ir_stage u_ir (
        .clk(clk), .rst(rst), .cyc_end(cyc_end), .kill(kill),
        .rdata(iword_t'(pm_rdata)), .ir(ir_q)
    );

    assign fetch_stb = (ph == PH_WRITE);
    assign instr     = W'(ir_q);
endmodule

// File: rtl/qps_sequencer_chk.sv
module qps_sequencer_chk #(
    parameter int W = 14,
    parameter int P = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] pm_rdata,
    input logic         flush_req,
    input logic [P-1:0] phase_stb,
    input logic         fetch_stb,
    input logic [W-1:0] instr
);
    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (phase_stb == 4'b0001 && instr == '0 && !fetch_stb));

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_stb) == 1);

    assert_rotate_R3: assert property (@(posedge clk) disable iff (rst)
        since_rst != 3'd0 |->
        phase_stb == {$past(phase_stb[P-2:0]), $past(phase_stb[P-1])});

    assert_fetch_once_R4: assert property (@(posedge clk) disable iff (rst)
        fetch_stb |=> (phase_stb[0] && !fetch_stb));

    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5 && phase_stb[0] && !$past(flush_req, 1) && !$past(flush_req, 2)
         && !$past(flush_req, 3) && !$past(flush_req, 4))
        |-> instr == $past(pm_rdata));

    assert_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 3'd0 && !phase_stb[0]) |-> $stable(instr));

    assert_flush_nop_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 3'd0 && phase_stb[0] && $past(flush_req)) |-> instr == '0);
endmodule

bind qps_sequencer qps_sequencer_chk #(.W(W), .P(P)) u_chk (
    .clk(clk), .rst(rst), .pm_rdata(pm_rdata), .flush_req(flush_req),
    .phase_stb(phase_stb), .fetch_stb(fetch_stb), .instr(instr)
);

// File: tb/sim_qps_sequencer.sv
`timescale 1ns/1ps
module sim_qps_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] pm_rdata = '0;
    logic        flush_req = 1'b0;
    logic [3:0]  phase_stb;
    logic        fetch_stb;
    logic [13:0] instr;

    int total = 0;
    int bad   = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;
    int cyc    = 0;
    logic [13:0] exp_q[$];
    logic [3:0]  prev_ph;
    logic [13:0] prev_ir;

    always #2 clk = ~clk;

    qps_sequencer u0 (
        .clk(clk), .rst(rst), .pm_rdata(pm_rdata), .flush_req(flush_req),
        .phase_stb(phase_stb), .fetch_stb(fetch_stb), .instr(instr)
    );

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Driver: one instruction cycle, aligned to phase bit 0 at a falling edge.
    // fph = phase index carrying the flush, or -1 for none.
    task automatic run_cycle(logic [13:0] word, int fph);
        exp_q.push_back((fph >= 0) ? 14'h0000 : word);
        for (int p = 0; p < 4; p++) begin
            pm_rdata  = (p == 3) ? word : (word ^ 14'h2A5B ^ 14'(p + 1)); // R9 filler
            flush_req = (p == fph);
            @(negedge clk);
        end
        flush_req = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            check($countones(phase_stb) == 1, "R2", 32'(phase_stb), 32'd1);
            check(phase_stb == {prev_ph[2:0], prev_ph[3]}, "R3", 32'(phase_stb),
                  32'({prev_ph[2:0], prev_ph[3]}));
            check(fetch_stb == phase_stb[3], "R4", 32'(fetch_stb), 32'(phase_stb[3]));
            if (phase_stb[0]) begin
                if (exp_q.size() == 0) check(1'b0, "R5", 32'(instr), 32'hFFFF_FFFF);
                else begin
                    logic [13:0] e;
                    e = exp_q.pop_front();
                    check(instr == e, "R5/R7/R8", 32'(instr), 32'(e));
                end
            end else begin
                check(instr == prev_ir, "R6", 32'(instr), 32'(prev_ir));
            end
        end
        prev_ph = phase_stb;
        prev_ir = instr;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(phase_stb == 4'b0001, "R1", 32'(phase_stb), 32'h1);
        check(instr == 14'h0000, "R1", 32'(instr), 32'h0);
        check(fetch_stb == 1'b0, "R1", 32'(fetch_stb), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        // first clock after reset: still decode phase until next edge? No: an edge passed.
        check(phase_stb == 4'b0010, "R3", 32'(phase_stb), 32'h2);
        check(instr == 14'h0000, "R1", 32'(instr), 32'h0);
        // realign to phase bit 0
        while (!phase_stb[0]) @(negedge clk);
        exp_q.push_back(14'h0000);   // R1: first cycle runs a NOP
        prev_ph = 4'b1000;
        prev_ir = instr;
        mon_on = 1'b1;
        // R5 normal stream with R9 filler
        run_cycle(14'h0123, -1);
        run_cycle(14'h3FFF, -1);
        run_cycle(14'h1555, -1);
        run_cycle(14'h0000, -1);
        // R7 flush on each phase, R8 recovery after each
        for (int f = 0; f < 4; f++) begin
            run_cycle(14'h0A00 + 14'(f), f);
            run_cycle(14'h2B00 + 14'(f), -1);
        end
        // back-to-back flushes, then recovery
        run_cycle(14'h3FFF, 1);
        run_cycle(14'h1111, 3);
        run_cycle(14'h2222, -1);
        run_cycle(14'h3333, -1);
        @(negedge clk);
        mon_on = 1'b0;
        check(exp_q.size() == 0, "R5", 32'(exp_q.size()), 32'd0);
        finish_up();
    end
endmodule